// File: doc/BRIEF.md
# EDO DRAM Cycle Decoder

This block monitors the control strobes of a 1M x 16 extended-data-out DRAM with a multiplexed 10-bit address bus. It tells a bus monitor, protocol checker or memory model what each access is, using only the order in which the strobes change. It samples the row strobe, the lower and upper column strobes, write enable, output enable and the address bus on a fast system clock. Strobes and address pass together through a synchroniser. Each sample is compared with the one before it to find edges.

Each decoded cycle is reported as a single-clock valid pulse with a type code, and the row, column and byte-lane enables are captured alongside it. The block holds its own refresh-row counter. That counter supplies the row for refreshes that start with a column strobe, either a column strobe falling before the row strobe or a column strobe held low across a new row strobe. The counter steps after each such refresh.

Top module: `edo_cycle_decoder`

## Requirements
- R1: After reset, `cyc_valid` is 0 and `row_addr`, `col_addr`, `lane_en` and `rfsh_row` are all 0. The refresh counter starts at row 0.
- R2: Type codes on `cyc_type` are: standby 0, read 1, early write 2, read-write 3, page continuation 4, row-only refresh 5, CAS-before-RAS refresh 6, hidden refresh 7. A row strobe falling with both column strobes high latches `addr` as the row. The first column strobe to fall after that latches `addr` as the column. If `we_n` is high at that fall, the cycle is reported as a read (1).
- R3: If `we_n` is low when the first column strobe falls, the cycle is reported as an early write (2), with the row and column captured the same way as a read.
- R4: `lane_en[0]` is set when `lcas_n` is low and `lane_en[1]` when `ucas_n` is low, both sampled at the column-strobe fall. A lane whose strobe stays high is 0.
- R5: While the row strobe stays low, each later fall of the column strobes from all-high reports a page continuation (4). It latches a new column and new lane enables and leaves the row unchanged.
- R6: A row strobe that falls with both column strobes high and rises again with no column strobe in between reports a row-only refresh (5) on the rise. The row reported is the one latched at the fall, and `lane_en` is 0.
- R7: A column strobe low before the row strobe falls reports a CAS-before-RAS refresh (6). The row and column outputs keep their values whatever is on `addr`, `lane_en` is 0, and `rfsh_row` shows the refresh counter.
- R8: A column strobe held low from an access while the row strobe rises and falls again reports a hidden refresh (7) on the new fall. `lane_en`, the row and the column are unchanged, and `rfsh_row` shows the refresh counter.
- R9: The refresh counter steps by one after every refresh of type 6 or 7 and wraps from 1023 to 0. It changes at no other time.
- R10: After a read, a fall of `we_n` reports a read-write (3) if `oe_n` is high and the row and a column strobe are still low. It is reported at most once per column access. A `we_n` fall with `oe_n` low reports nothing.
- R11: When all three strobes return high, a standby (0) is reported and `lane_en` clears. The exception is a return that completes a row-only refresh, which is reported as type 5 instead.
- R12: Each report is a one-clock pulse on `cyc_valid`. With the default two synchroniser stages, it appears on the third rising clock edge after the strobe edge is presented.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ras_n | input | 1 | Row strobe, active low |
| lcas_n | input | 1 | Lower-byte column strobe, active low |
| ucas_n | input | 1 | Upper-byte column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| oe_n | input | 1 | Output enable, active low |
| addr | input | 10 | Multiplexed row/column address |
| cyc_valid | output | 1 | One-clock pulse marking a decoded cycle |
| cyc_type | output | 3 | Decoded cycle code |
| row_addr | output | 10 | Latched row |
| col_addr | output | 10 | Latched column |
| lane_en | output | 2 | Byte lane enables {upper, lower} |
| rfsh_row | output | 10 | Row supplied by the refresh counter for the last refresh |

## Verification
Most state faults show up at the very next decoded cycle, because every pulse carries the type, row, column and lane fields. A decoder left in the wrong state misclassifies the next strobe edge, for example reporting a read as a page continuation or a refresh as a row open, within three clocks of that edge. A counter fault is different. It stays hidden until the next refresh of type 6 or 7, and then `rfsh_row` shows it. The wrap from 1023 to 0 only appears after a full sweep of refreshes, so the bench runs one.

// File: rtl/edo_pkg.sv
`timescale 1ns/1ps
package edo_pkg;

    typedef enum logic [2:0] {
        CY_STANDBY = 3'd0,
        CY_READ    = 3'd1,
        CY_EWRITE  = 3'd2,
        CY_RDWR    = 3'd3,
        CY_PAGE    = 3'd4,
        CY_RASONLY = 3'd5,
        CY_CBR     = 3'd6,
        CY_HIDDEN  = 3'd7
    } cyc_e;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_CBR_ARM = 3'd1,
        ST_ROW     = 3'd2,
        ST_ACC     = 3'd3,
        ST_HOLD    = 3'd4,
        ST_RFSH    = 3'd5
    } dec_st_e;

    typedef struct packed {
        logic ras_n;
        logic lcas_n;
        logic ucas_n;
        logic we_n;
        logic oe_n;
    } strobe_t;

    localparam int STROBE_W = $bits(strobe_t);

    typedef struct packed {
        logic       ras_fall;
        logic       ras_rise;
        logic       cas_fall;
        logic       we_fall;
        logic       cas_low;
        logic       we_n;
        logic       oe_n;
        logic       all_high_now;
        logic       all_high_prev;
        logic [1:0] lanes;
    } edge_t;

endpackage

// File: rtl/edo_sync.sv
`timescale 1ns/1ps
module edo_sync #(
    parameter int             W       = 8,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign dout = stg_q[STAGES-1];
endmodule

// File: rtl/edo_edge.sv
`timescale 1ns/1ps
module edo_edge
    import edo_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  strobe_t cur,
    output edge_t   ev
);
    strobe_t prev_q, prev_d;
    logic    cas_low_c, cas_low_p;

    always_comb begin
        prev_d    = cur;
        cas_low_c = !cur.lcas_n || !cur.ucas_n;
        cas_low_p = !prev_q.lcas_n || !prev_q.ucas_n;

        ev.ras_fall      = prev_q.ras_n && !cur.ras_n;
        ev.ras_rise      = !prev_q.ras_n && cur.ras_n;
        ev.cas_fall      = cas_low_c && !cas_low_p;
        ev.we_fall       = prev_q.we_n && !cur.we_n;
        ev.cas_low       = cas_low_c;
        ev.we_n          = cur.we_n;
        ev.oe_n          = cur.oe_n;
        ev.all_high_now  = cur.ras_n && !cas_low_c;
        ev.all_high_prev = prev_q.ras_n && !cas_low_p;
        ev.lanes         = {!cur.ucas_n, !cur.lcas_n};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '1;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/edo_rfsh_ctr.sv
`timescale 1ns/1ps
module edo_rfsh_ctr #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc,
    output logic [W-1:0] cnt
);
    logic [W-1:0] cnt_q, cnt_d;

    always_comb begin
        cnt_d = cnt_q;
        if (inc) cnt_d = cnt_q + W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;
endmodule

// File: rtl/edo_cycle_decoder.sv
`timescale 1ns/1ps
module edo_cycle_decoder
    import edo_pkg::*;
#(
    parameter int ADDR_W      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ras_n,
    input  logic              lcas_n,
    input  logic              ucas_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    output logic              cyc_valid,
    output logic [2:0]        cyc_type,
    output logic [ADDR_W-1:0] row_addr,
    output logic [ADDR_W-1:0] col_addr,
    output logic [1:0]        lane_en,
    output logic [ADDR_W-1:0] rfsh_row
);
    localparam int                SYNC_W   = STROBE_W + ADDR_W;
    localparam logic [SYNC_W-1:0] SYNC_RST = {{STROBE_W{1'b1}}, {ADDR_W{1'b0}}};

    typedef struct packed {
        dec_st_e           st;
        logic [ADDR_W-1:0] row;
        logic [ADDR_W-1:0] col;
        logic [ADDR_W-1:0] rfsh;
        logic [1:0]        lane;
        logic              valid;
        cyc_e              ctype;
        logic              acc_read;
        logic              rw_done;
    } dec_t;

    logic [SYNC_W-1:0] sync_out;
    strobe_t           strb_s;
    logic [ADDR_W-1:0] addr_s;
    edge_t             ev;
    logic [ADDR_W-1:0] ctr_w;
    logic              ctr_inc;
    dec_t              q, d;

    edo_sync #(
        .W       (SYNC_W),
        .STAGES  (SYNC_STAGES),
        .RST_VAL (SYNC_RST)
    ) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({ras_n, lcas_n, ucas_n, we_n, oe_n, addr}),
        .dout (sync_out)
    );

    assign strb_s = strobe_t'(sync_out[SYNC_W-1:ADDR_W]);
    assign addr_s = sync_out[ADDR_W-1:0];

    edo_edge u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .cur  (strb_s),
        .ev   (ev)
    );

    edo_rfsh_ctr #(.W(ADDR_W)) u_ctr (
        .clk  (clk),
        .rst_n(rst_n),
        .inc  (ctr_inc),
        .cnt  (ctr_w)
    );

    always_comb begin
        d       = q;
        d.valid = 1'b0;
        ctr_inc = 1'b0;

        case (q.st)
            ST_IDLE: begin
                if (ev.ras_fall) begin
                    if (ev.cas_low) begin
                        d.valid = 1'b1;
                        d.ctype = CY_CBR;
                        d.rfsh  = ctr_w;
                        d.lane  = '0;
                        ctr_inc = 1'b1;
                        d.st    = ST_RFSH;
                    end else begin
                        d.row  = addr_s;
                        d.lane = '0;
                        d.st   = ST_ROW;
                    end
                end else if (ev.cas_fall) begin
                    d.st = ST_CBR_ARM;
                end
            end
            ST_CBR_ARM: begin
                if (ev.ras_fall) begin
                    if (ev.cas_low) begin
                        d.valid = 1'b1;
                        d.ctype = CY_CBR;
                        d.rfsh  = ctr_w;
                        d.lane  = '0;
                        ctr_inc = 1'b1;
                        d.st    = ST_RFSH;
                    end else begin
                        d.row  = addr_s;
                        d.lane = '0;
                        d.st   = ST_ROW;
                    end
                end else if (!ev.cas_low) begin
                    d.st = ST_IDLE;
                end
            end
            ST_ROW: begin
                if (ev.ras_rise) begin
                    d.valid = 1'b1;
                    d.ctype = CY_RASONLY;
                    d.lane  = '0;
                    d.st    = ST_IDLE;
                end else if (ev.cas_fall) begin
                    d.valid    = 1'b1;
                    d.ctype    = ev.we_n ? CY_READ : CY_EWRITE;
                    d.col      = addr_s;
                    d.lane     = ev.lanes;
                    d.acc_read = ev.we_n;
                    d.rw_done  = 1'b0;
                    d.st       = ST_ACC;
                end
            end
            ST_ACC: begin
                if (ev.ras_rise) begin
                    d.st = ev.cas_low ? ST_HOLD : ST_IDLE;
                end else if (ev.cas_fall) begin
                    d.valid    = 1'b1;
                    d.ctype    = CY_PAGE;
                    d.col      = addr_s;
                    d.lane     = ev.lanes;
                    d.acc_read = ev.we_n;
                    d.rw_done  = 1'b0;
                end else if (ev.we_fall && ev.cas_low && ev.oe_n &&
                             q.acc_read && !q.rw_done) begin
                    d.valid   = 1'b1;
                    d.ctype   = CY_RDWR;
                    d.rw_done = 1'b1;
                end
            end
            ST_HOLD: begin
                if (ev.ras_fall && ev.cas_low) begin
                    d.valid = 1'b1;
                    d.ctype = CY_HIDDEN;
                    d.rfsh  = ctr_w;
                    ctr_inc = 1'b1;
                    d.st    = ST_RFSH;
                end else if (!ev.cas_low) begin
                    d.st = ST_IDLE;
                end
            end
            ST_RFSH: begin
                if (ev.ras_rise) begin
                    d.st = ev.cas_low ? ST_CBR_ARM : ST_IDLE;
                end
            end
            default: d.st = ST_IDLE;
        endcase

        if (!d.valid && ev.all_high_now && !ev.all_high_prev) begin
            d.valid = 1'b1;
            d.ctype = CY_STANDBY;
            d.lane  = '0;
            d.st    = ST_IDLE;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q          <= '0;
            q.st       <= ST_IDLE;
            q.ctype    <= CY_STANDBY;
        end else begin
            q <= d;
        end
    end

    assign cyc_valid = q.valid;
    assign cyc_type  = q.ctype;
    assign row_addr  = q.row;
    assign col_addr  = q.col;
    assign lane_en   = q.lane;
    assign rfsh_row  = q.rfsh;
endmodule

// File: rtl/edo_cycle_decoder_chk.sv
`timescale 1ns/1ps
module edo_cycle_decoder_chk
    import edo_pkg::*;
#(
    parameter int W = 10
) (
    input logic         clk,
    input logic         rst_n,
    input logic         valid,
    input logic [2:0]   ctype,
    input logic [W-1:0] row,
    input logic [W-1:0] col,
    input logic [1:0]   lane,
    input logic [W-1:0] rfsh,
    input logic [W-1:0] ctr
);
    logic is_rf;
    assign is_rf = valid && (ctype == CY_CBR || ctype == CY_HIDDEN);

    p_ctr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
        is_rf |-> ctr == $past(ctr) + W'(1));

    p_ctr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !is_rf |-> $stable(ctr));

    p_rfsh_src_r7: assert property (@(posedge clk) disable iff (!rst_n)
        is_rf |-> rfsh == $past(ctr));

    p_cbr_keep_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ctype == CY_CBR) |-> ($stable(row) && $stable(col) && lane == 2'b00));

    p_rasonly_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ctype == CY_RASONLY) |-> ($stable(row) && lane == 2'b00));

    p_hidden_lane_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ctype == CY_HIDDEN) |-> ($stable(lane) && $stable(row) && $stable(col)));

    p_lane_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && (ctype == CY_READ || ctype == CY_EWRITE || ctype == CY_PAGE)) |-> lane != 2'b00);

    p_standby_lane_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && ctype == CY_STANDBY) |-> lane == 2'b00);
endmodule

bind edo_cycle_decoder edo_cycle_decoder_chk #(.W(ADDR_W)) u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .valid(cyc_valid),
    .ctype(cyc_type),
    .row  (row_addr),
    .col  (col_addr),
    .lane (lane_en),
    .rfsh (rfsh_row),
    .ctr  (ctr_w)
);

// File: tb/edo_cycle_decoder_bench.sv
`timescale 1ns/1ps
module edo_cycle_decoder_bench;
    import edo_pkg::*;

    localparam int AW   = 10;
    localparam int HOLD = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ras_n = 1'b1, lcas_n = 1'b1, ucas_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
    logic [AW-1:0] addr = '0;
    logic          cyc_valid;
    logic [2:0]    cyc_type;
    logic [AW-1:0] row_addr, col_addr, rfsh_row;
    logic [1:0]    lane_en;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    int drv_cyc = 0;
    int ev_cnt = 0;
    int ev_before = 0;
    int ev_lat = 0;
    logic          prev_v = 1'b0;
    logic [2:0]    ev_type;
    logic [AW-1:0] ev_row, ev_col, ev_rf;
    logic [1:0]    ev_lane;
    logic [AW-1:0] m_row = '0, m_col = '0, m_ctr = '0;
    logic [1:0]    m_lane = '0;
    logic          cur_l = 1'b1, cur_u = 1'b1;
    bit            done = 1'b0;

    always #2.5 clk = ~clk;

    edo_cycle_decoder u_edo_cycle_decoder (
        .clk(clk), .rst_n(rst_n), .ras_n(ras_n), .lcas_n(lcas_n), .ucas_n(ucas_n),
        .we_n(we_n), .oe_n(oe_n), .addr(addr), .cyc_valid(cyc_valid),
        .cyc_type(cyc_type), .row_addr(row_addr), .col_addr(col_addr),
        .lane_en(lane_en), .rfsh_row(rfsh_row)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (cyc_valid) begin
                if (prev_v) begin
                    checks++; errors++;
                    $display("FAIL R12: pulse longer than one clock, got 2 expected 1");
                end
                ev_cnt++;
                ev_type = cyc_type; ev_row = row_addr; ev_col = col_addr;
                ev_lane = lane_en;  ev_rf  = rfsh_row;
                ev_lat  = cyc - drv_cyc;
            end
            prev_v = cyc_valid;
        end
    end

    function automatic logic [1:0] lanes_of(logic l, logic u);
        return {~u, ~l};
    endfunction

    function automatic cyc_e first_type(logic w);
        return w ? CY_READ : CY_EWRITE;
    endfunction

    function automatic logic [AW-1:0] ctr_next(logic [AW-1:0] c);
        return (c == AW'(1023)) ? '0 : c + AW'(1);
    endfunction

    task automatic drive(input logic r, l, u, w, o, input logic [AW-1:0] a);
        @(negedge clk);
        ras_n = r; lcas_n = l; ucas_n = u; we_n = w; oe_n = o; addr = a;
        drv_cyc = cyc; ev_before = ev_cnt;
        repeat (HOLD) @(negedge clk);
        #1;
    endtask

    task automatic chk_ev(input cyc_e t, input logic [AW-1:0] r, c, rf,
                          input logic [1:0] ln, input bit use_rf, input string req);
        bit ok;
        checks++;
        ok = (ev_cnt == ev_before + 1) && (ev_type == t) && (ev_row == r) &&
             (ev_col == c) && (ev_lane == ln) && (!use_rf || ev_rf == rf);
        if (!ok) begin
            errors++;
            $display("FAIL %s: got n=%0d type=%0d row=%h col=%h lane=%b rf=%h expected n=1 type=%0d row=%h col=%h lane=%b rf=%h",
                     req, ev_cnt - ev_before, ev_type, ev_row, ev_col, ev_lane, ev_rf,
                     t, r, c, ln, rf);
        end
    endtask

    task automatic chk_none(input string req);
        checks++;
        if (ev_cnt != ev_before) begin
            errors++;
            $display("FAIL %s: got %0d reports expected 0", req, ev_cnt - ev_before);
        end
    endtask

    task automatic chk_int(input string req, input int got, input int exp);
        checks++;
        if (got != exp) begin
            errors++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic open_row(input logic [AW-1:0] r);
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, r);
        m_row = r;
        chk_none("R2 row open");
    endtask

    task automatic cas_on(input logic l, u, w, o, input logic [AW-1:0] c, input bit first);
        drive(1'b0, l, u, w, o, c);
        cur_l = l; cur_u = u;
        m_col = c; m_lane = lanes_of(l, u);
        chk_ev(first ? first_type(w) : CY_PAGE, m_row, m_col, '0, m_lane, 1'b0,
               first ? (w ? "R2 read" : "R3 early write") : "R5 page");
    endtask

    task automatic cas_off();
        drive(1'b0, 1'b1, 1'b1, 1'b1, 1'b0, AW'($urandom));
        cur_l = 1'b1; cur_u = 1'b1;
        chk_none("R5 cas up");
    endtask

    task automatic close_all();
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, AW'($urandom));
        cur_l = 1'b1; cur_u = 1'b1;
        m_lane = '0;
        chk_ev(CY_STANDBY, m_row, m_col, '0, 2'b00, 1'b0, "R11 standby");
    endtask

    task automatic hidden_after();
        drive(1'b1, cur_l, cur_u, 1'b1, 1'b0, AW'($urandom));
        chk_none("R8 row strobe up with cas held");
        drive(1'b0, cur_l, cur_u, 1'b1, 1'b0, AW'($urandom));
        chk_ev(CY_HIDDEN, m_row, m_col, m_ctr, m_lane, 1'b1, "R8 hidden");
        m_ctr = ctr_next(m_ctr);
        drive(1'b1, cur_l, cur_u, 1'b1, 1'b0, AW'($urandom));
        chk_none("R8 hidden end");
        close_all();
    endtask

    task automatic cbr_pulse(input logic l, u, input string req);
        drive(1'b0, l, u, 1'b1, 1'b0, AW'($urandom));
        chk_ev(CY_CBR, m_row, m_col, m_ctr, 2'b00, 1'b1, req);
        m_ctr = ctr_next(m_ctr);
        m_lane = '0;
        drive(1'b1, l, u, 1'b1, 1'b0, AW'($urandom));
        chk_none("R7 row strobe up in refresh");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h00C0FFEE));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1 reset values
        chk_int("R1 valid", int'(cyc_valid), 0);
        chk_int("R1 row", int'(row_addr), 0);
        chk_int("R1 col", int'(col_addr), 0);
        chk_int("R1 lane", int'(lane_en), 0);
        chk_int("R1 rfsh", int'(rfsh_row), 0);

        // R2 word read, R12 latency, R5 page, R4 lanes
        open_row(AW'(10'h155));
        cas_on(1'b0, 1'b0, 1'b1, 1'b0, AW'(10'h2AA), 1'b1);
        chk_int("R12 latency", ev_lat, 3);
        cas_off();
        cas_on(1'b0, 1'b1, 1'b1, 1'b0, AW'(10'h3FF), 1'b0);
        chk_int("R4 lower lane only", int'(ev_lane), 1);
        cas_off();
        cas_on(1'b1, 1'b0, 1'b1, 1'b0, AW'(10'h001), 1'b0);
        chk_int("R4 upper lane only", int'(ev_lane), 2);
        cas_off();
        close_all();

        // R3 early write on upper lane
        open_row(AW'(10'h3FF));
        cas_on(1'b1, 1'b0, 1'b0, 1'b1, AW'(10'h000), 1'b1);
        cas_off();
        close_all();

        // R6 row-only refresh
        open_row(AW'(10'h02A));
        drive(1'b1, 1'b1, 1'b1, 1'b1, 1'b0, AW'(10'h3C3));
        chk_ev(CY_RASONLY, AW'(10'h02A), m_col, '0, 2'b00, 1'b0, "R6 row-only");
        m_lane = '0;

        // R10 read-write
        open_row(AW'(10'h0F0));
        cas_on(1'b0, 1'b0, 1'b1, 1'b0, AW'(10'h10F), 1'b1);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, AW'(0));
        chk_none("R10 we fall with oe low");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, AW'(0));
        chk_none("R10 we up");
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, AW'(0));
        chk_ev(CY_RDWR, m_row, m_col, '0, m_lane, 1'b0, "R10 read-write");
        drive(1'b0, 1'b0, 1'b0, 1'b1, 1'b1, AW'(0));
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, AW'(0));
        chk_none("R10 second we fall");
        cas_off();
        close_all();

        // R7 CBR refresh, repeated with cas held
        drive(1'b1, 1'b0, 1'b1, 1'b1, 1'b0, AW'(10'h123));
        chk_none("R7 cas first");
        cbr_pulse(1'b0, 1'b1, "R7 cbr");
        cbr_pulse(1'b0, 1'b1, "R7 cbr repeat");
        close_all();

        // R8 hidden refresh after a read
        open_row(AW'(10'h077));
        cas_on(1'b0, 1'b0, 1'b1, 1'b0, AW'(10'h088), 1'b1);
        hidden_after();

        // R9 counter wrap through a full sweep
        drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, AW'(0));
        chk_none("R9 cas first");
        for (int i = 0; i < 1030; i++) begin
            cbr_pulse(1'b0, 1'b0, (m_ctr == AW'(1023) || m_ctr == AW'(0)) ? "R9 wrap" : "R9 step");
        end
        close_all();

        // Random accesses with page continuations and optional hidden refresh
        for (int n = 0; n < 60; n++) begin
            logic [1:0] ln;
            int pages;
            open_row(AW'($urandom));
            ln = 2'($urandom_range(1, 3));
            cas_on(~ln[0], ~ln[1], 1'($urandom), 1'b0, AW'($urandom), 1'b1);
            pages = $urandom_range(0, 3);
            for (int p = 0; p < pages; p++) begin
                logic [1:0] pl;
                cas_off();
                pl = 2'($urandom_range(1, 3));
                cas_on(~pl[0], ~pl[1], 1'($urandom), 1'b0, AW'($urandom), 1'b0);
            end
            if ($urandom_range(0, 3) == 0) begin
                hidden_after();
            end else begin
                cas_off();
                close_all();
            end
        end

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule